// File: doc/BRIEF.md
# Run-Time Programmable Cascaded Integrator-Comb Decimator

This block reduces the sample rate of one real, signed data stream by an integer factor R with a cascaded integrator-comb filter. The number of integrator/comb pairs N can be changed at run time between 1 and 5. Stages above the chosen order are bypassed. Each input sample passes through a left barrel shifter before the first integrator. The shift lets the system place the data inside the fixed accumulator width so that the gain R^N never overflows it.

Software writes a requested order, ratio, input shift and output shift, then pulses a load strobe. The load stores the values and clears all filter state. If the requested order or ratio is outside the legal set, the block moves it to the nearest legal value and raises an error flag. The largest legal ratio shrinks as the order grows, so the bit growth N·log2(R) stays within a 45-bit budget. Every R-th accepted sample produces one output word. This word is the comb result, shifted right arithmetically and then cut back to the input width.

Top module: `cic_decim`

## Requirements
- R1: An order request of 0 becomes order 1, and a request of 6 or 7 becomes order 5. Each of these substitutions sets `cfg_err`. A request of 1 to 5 is used as given.
- R2: A ratio request below 4 becomes 4 and sets `cfg_err`.
- R3: A ratio request above the limit for the effective order is replaced by that limit and sets `cfg_err`. The limits are 65536 for order 1 or 2, 32768 for order 3, 2048 for order 4 and 512 for order 5. A load with no substitution clears `cfg_err`. The flag becomes valid one clock edge after the load edge.
- R4: `out_valid` is a one-cycle strobe that fires once for every R samples accepted with `in_valid` high. It rises on the second clock edge after the edge that accepts the R-th sample.
- R5: Integrator k (k = 1..N) adds to itself, on every accepted sample, the value stage k-1 held before that edge. Stage 0 is the scaled input. On each decimation the value of integrator N passes through N comb stages. Each comb stage outputs its input minus the input it saw at the previous decimation.
- R6: Before the first integrator, the input is sign-extended to 61 bits and shifted left by the loaded input-shift amount (0 to 63).
- R7: The comb result is shifted right arithmetically by the loaded output-shift amount. `out_data` is bits 15:0 of that result.
- R8: A load clears the integrators, combs and sample count. A sample offered in the load cycle is ignored.
- R9: Cycles with `in_valid` low change neither the sample count nor any filter state.
- R10: All integrator and comb arithmetic is 61-bit two's complement that wraps on overflow.
- R11: After reset the block holds order 1, ratio 4 and zero shifts. `out_valid`, `out_data` and `cfg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Stores the requested configuration and clears the filter |
| cfg_order | input | 3 | Requested filter order |
| cfg_ratio | input | 17 | Requested decimation ratio |
| cfg_pre_shift | input | 6 | Left shift applied to each input sample |
| cfg_out_shift | input | 6 | Arithmetic right shift applied before truncation |
| cfg_err | output | 1 | Last load needed its order or ratio corrected |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Decimated output strobe |
| out_data | output | 16 | Signed decimated output |

## Verification
Each decimated word is due on the second clock edge after the edge that takes in the R-th sample. The error flag is due one edge after the load edge. The driver stamps every expected word with the cycle number at which it must appear. The monitor samples on the falling edge and compares both the value and that cycle stamp, so an early, late, missing or extra strobe is reported. Loads are only issued after the pipeline has drained, which means no pending word is lost across a reconfiguration.

// File: rtl/cic_pkg.sv
package cic_pkg;

   // Reasons a requested configuration was altered at load time
   typedef struct packed {
      logic order_fix;
      logic ratio_fix;
   } clamp_t;

   // Largest ratio whose growth order*log2(ratio) stays within the budget,
   // further capped by the ratio field width.
   function automatic int unsigned ratio_limit(input int unsigned order,
                                               input int unsigned growth,
                                               input int unsigned ratio_w);
      int unsigned o;
      int unsigned e;
      o = (order == 0) ? 1 : order;
      e = growth / o;
      if (e > ratio_w - 1) e = ratio_w - 1;
      return 32'd1 << e;
   endfunction

endpackage

// File: rtl/cic_cfg_clamp.sv
module cic_cfg_clamp
   import cic_pkg::*;
#(
   parameter int MAX_ORDER   = 5,
   parameter int ORD_W       = 3,
   parameter int RATIO_W     = 17,
   parameter int GROWTH_BITS = 45,
   parameter int MIN_RATIO   = 4
) (
   input  logic [ORD_W-1:0]   req_order,
   input  logic [RATIO_W-1:0] req_ratio,
   output logic [ORD_W-1:0]   eff_order,
   output logic [RATIO_W-1:0] eff_ratio,
   output clamp_t             flags
);

   logic [MAX_ORDER:1][RATIO_W-1:0] lim_tab;
   logic [RATIO_W-1:0]              lim;

   for (genvar o = 1; o <= MAX_ORDER; o++) begin : g_lim
      assign lim_tab[o] = RATIO_W'(ratio_limit(o, GROWTH_BITS, RATIO_W));
   end

   always_comb begin
      flags     = '0;
      eff_order = req_order;
      if (req_order == '0) begin
         eff_order       = ORD_W'(1);
         flags.order_fix = 1'b1;
      end else if (req_order > ORD_W'(MAX_ORDER)) begin
         eff_order       = ORD_W'(MAX_ORDER);
         flags.order_fix = 1'b1;
      end
      lim       = lim_tab[eff_order];
      eff_ratio = req_ratio;
      if (req_ratio < RATIO_W'(MIN_RATIO)) begin
         eff_ratio       = RATIO_W'(MIN_RATIO);
         flags.ratio_fix = 1'b1;
      end else if (req_ratio > lim) begin
         eff_ratio       = lim;
         flags.ratio_fix = 1'b1;
      end
   end

endmodule

// File: rtl/cic_barrel_shl.sv
module cic_barrel_shl #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 61,
   parameter int SH_W  = 6
) (
   input  logic [IN_W-1:0]  din,
   input  logic [SH_W-1:0]  amt,
   output logic [OUT_W-1:0] dout
);

   logic [SH_W:0][OUT_W-1:0] stg;

   assign stg[0] = {{(OUT_W-IN_W){din[IN_W-1]}}, din};

   for (genvar b = 0; b < SH_W; b++) begin : g_lvl
      assign stg[b+1] = amt[b] ? (stg[b] << (1 << b)) : stg[b];
   end

   assign dout = stg[SH_W];

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
   parameter int ACC_W     = 61,
   parameter int MAX_ORDER = 5,
   parameter int ORD_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [ACC_W-1:0] din,
   input  logic [ORD_W-1:0] order,
   output logic [ACC_W-1:0] tap
);

   logic [MAX_ORDER-1:0][ACC_W-1:0] taps;

   for (genvar k = 0; k < MAX_ORDER; k++) begin : g_st
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] src;
      logic             act;

      if (k == 0) begin : g_head
         assign src = din;
      end else begin : g_link
         assign src = g_st[k-1].acc;
      end

      assign act = (ORD_W'(k) < order);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc <= '0;
         else if (clr)    acc <= '0;
         else if (en)     acc <= act ? (acc + src) : '0;
      end

      assign taps[k] = acc;
   end

   assign tap = taps[order - ORD_W'(1)];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
   parameter int ACC_W     = 61,
   parameter int MAX_ORDER = 5,
   parameter int ORD_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [ACC_W-1:0] din,
   input  logic [ORD_W-1:0] order,
   output logic [ACC_W-1:0] dout
);

   logic [MAX_ORDER:0][ACC_W-1:0] link;

   assign link[0] = din;

   for (genvar k = 0; k < MAX_ORDER; k++) begin : g_st
      logic [ACC_W-1:0] dly;
      logic             act;

      assign act = (ORD_W'(k) < order);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              dly <= '0;
         else if (clr)            dly <= '0;
         else if (step && act)    dly <= link[k];
      end

      assign link[k+1] = act ? (link[k] - dly) : link[k];
   end

   assign dout = link[MAX_ORDER];

endmodule

// File: rtl/cic_decim.sv
module cic_decim
   import cic_pkg::*;
#(
   parameter int  DATA_W      = 16,
   parameter int  MAX_ORDER   = 5,
   parameter int  GROWTH_BITS = 45,
   parameter int  RATIO_W     = 17,
   parameter int  MIN_RATIO   = 4,
   localparam int ACC_W       = DATA_W + GROWTH_BITS,
   localparam int ORD_W       = $clog2(MAX_ORDER + 1),
   localparam int SH_W        = $clog2(ACC_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [ORD_W-1:0]   cfg_order,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic [SH_W-1:0]    cfg_pre_shift,
   input  logic [SH_W-1:0]    cfg_out_shift,
   output logic               cfg_err,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_data,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data
);

   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_dw
      $error("cic_decim: DATA_W must be at least 2");
   end
   if (MAX_ORDER < 1) begin : g_bad_ord
      $error("cic_decim: MAX_ORDER must be at least 1");
   end
   if (MIN_RATIO < 2 || MIN_RATIO >= (1 << (RATIO_W - 1))) begin : g_bad_rmin
      $error("cic_decim: MIN_RATIO out of range for RATIO_W");
   end
   if (GROWTH_BITS < MAX_ORDER) begin : g_bad_grow
      $error("cic_decim: GROWTH_BITS too small for MAX_ORDER");
   end

   // Loaded configuration
   logic [ORD_W-1:0]   eff_order;
   logic [RATIO_W-1:0] eff_ratio;
   logic [SH_W-1:0]    eff_pre;
   logic [SH_W-1:0]    eff_osh;

   logic [ORD_W-1:0]   cl_order;
   logic [RATIO_W-1:0] cl_ratio;
   clamp_t             cl_flags;

   cic_cfg_clamp #(
      .MAX_ORDER  (MAX_ORDER),
      .ORD_W      (ORD_W),
      .RATIO_W    (RATIO_W),
      .GROWTH_BITS(GROWTH_BITS),
      .MIN_RATIO  (MIN_RATIO)
   ) u_clamp (
      .req_order(cfg_order),
      .req_ratio(cfg_ratio),
      .eff_order(cl_order),
      .eff_ratio(cl_ratio),
      .flags    (cl_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_order <= ORD_W'(1);
         eff_ratio <= RATIO_W'(MIN_RATIO);
         eff_pre   <= '0;
         eff_osh   <= '0;
         cfg_err   <= 1'b0;
      end else if (cfg_load) begin
         eff_order <= cl_order;
         eff_ratio <= cl_ratio;
         eff_pre   <= cfg_pre_shift;
         eff_osh   <= cfg_out_shift;
         cfg_err   <= cl_flags.order_fix | cl_flags.ratio_fix;
      end
   end

   // Sample counter and decimation event
   logic [RATIO_W-1:0] cnt;
   logic               dec_evt;
   logic               take;

   assign take = in_valid & ~cfg_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         dec_evt <= 1'b0;
      end else if (cfg_load) begin
         cnt     <= '0;
         dec_evt <= 1'b0;
      end else begin
         dec_evt <= 1'b0;
         if (in_valid) begin
            if (cnt == eff_ratio - RATIO_W'(1)) begin
               cnt     <= '0;
               dec_evt <= 1'b1;
            end else begin
               cnt <= cnt + RATIO_W'(1);
            end
         end
      end
   end

   // Input scaling
   logic [ACC_W-1:0] scaled;

   cic_barrel_shl #(
      .IN_W (DATA_W),
      .OUT_W(ACC_W),
      .SH_W (SH_W)
   ) u_pre (
      .din (in_data),
      .amt (eff_pre),
      .dout(scaled)
   );

   // Integrator and comb sections
   logic [ACC_W-1:0] int_tap;
   logic [ACC_W-1:0] comb_out;

   cic_integ_chain #(
      .ACC_W    (ACC_W),
      .MAX_ORDER(MAX_ORDER),
      .ORD_W    (ORD_W)
   ) u_integ (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_load),
      .en   (take),
      .din  (scaled),
      .order(eff_order),
      .tap  (int_tap)
   );

   cic_comb_chain #(
      .ACC_W    (ACC_W),
      .MAX_ORDER(MAX_ORDER),
      .ORD_W    (ORD_W)
   ) u_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_load),
      .step (dec_evt),
      .din  (int_tap),
      .order(eff_order),
      .dout (comb_out)
   );

   // Output scaling, truncation and strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (cfg_load) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= dec_evt;
         if (dec_evt) out_data <= DATA_W'($signed(comb_out) >>> eff_osh);
      end
   end

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk
   import cic_pkg::*;
#(
   parameter int MAX_ORDER   = 5,
   parameter int GROWTH_BITS = 45,
   parameter int RATIO_W     = 17,
   parameter int MIN_RATIO   = 4,
   parameter int ORD_W       = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_load,
   input logic [RATIO_W-1:0] cfg_ratio,
   input logic               cfg_err,
   input logic               in_valid,
   input logic               out_valid,
   input logic               dec_evt,
   input logic [RATIO_W-1:0] cnt,
   input logic [ORD_W-1:0]   eff_order,
   input logic [RATIO_W-1:0] eff_ratio
);

   p_order_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_order >= ORD_W'(1)) && (eff_order <= ORD_W'(MAX_ORDER)));

   p_err_low_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && (cfg_ratio < RATIO_W'(MIN_RATIO))) |=> cfg_err);

   p_ratio_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_ratio >= RATIO_W'(MIN_RATIO)) &&
      (eff_ratio <= RATIO_W'(ratio_limit(32'(eff_order), GROWTH_BITS, RATIO_W))));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < eff_ratio);

   p_out_after_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(dec_evt));

   p_out_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> ((cnt == '0) && !dec_evt));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !cfg_load) |=> $stable(cnt));

endmodule

bind cic_decim cic_decim_chk #(
   .MAX_ORDER  (MAX_ORDER),
   .GROWTH_BITS(GROWTH_BITS),
   .RATIO_W    (RATIO_W),
   .MIN_RATIO  (MIN_RATIO),
   .ORD_W      (ORD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .cfg_ratio(cfg_ratio),
   .cfg_err  (cfg_err),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .dec_evt  (dec_evt),
   .cnt      (cnt),
   .eff_order(eff_order),
   .eff_ratio(eff_ratio)
);

// File: tb/cic_decim_bench.sv
`timescale 1ns/1ps
module cic_decim_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_load;
   logic [2:0]  cfg_order;
   logic [16:0] cfg_ratio;
   logic [5:0]  cfg_pre_shift;
   logic [5:0]  cfg_out_shift;
   logic        cfg_err;
   logic        in_valid;
   logic [15:0] in_data;
   logic        out_valid;
   logic [15:0] out_data;

   always #2.5 clk = ~clk;

   cic_decim u_cic_decim (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_load     (cfg_load),
      .cfg_order    (cfg_order),
      .cfg_ratio    (cfg_ratio),
      .cfg_pre_shift(cfg_pre_shift),
      .cfg_out_shift(cfg_out_shift),
      .cfg_err      (cfg_err),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .out_valid    (out_valid),
      .out_data     (out_data)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Scoreboard
   logic [15:0] exp_q[$];
   int          due_q[$];
   string       tag_q[$];
   string       cur_tag = "R5";

   // Reference model state
   longint ig[5];
   longint cd[5];
   int     m_ord, m_rat, m_pre, m_osh, m_cnt;

   task automatic check(string req, longint act, longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic void model_reset();
      for (int k = 0; k < 5; k++) begin
         ig[k] = 0;
         cd[k] = 0;
      end
      m_cnt = 0;
   endfunction

   // Pipelined integrators: each stage adds the pre-edge value of the one before
   task automatic model_step(logic [15:0] x);
      longint xs, v, t, y;
      xs = longint'($signed(x)) <<< m_pre;
      for (int k = m_ord - 1; k >= 0; k--)
         ig[k] = ig[k] + ((k == 0) ? xs : ig[k-1]);
      m_cnt++;
      if (m_cnt == m_rat) begin
         m_cnt = 0;
         v = ig[m_ord-1];
         for (int k = 0; k < m_ord; k++) begin
            t = v - cd[k];
            cd[k] = v;
            v = t;
         end
         v = (v <<< 3) >>> 3;          // R10: 61-bit wrap
         y = v >>> m_osh;
         exp_q.push_back(y[15:0]);
         due_q.push_back(cyc + 2);
         tag_q.push_back(cur_tag);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // All driver tasks start and end on a falling edge
   task automatic push(logic [15:0] x);
      in_valid = 1'b1;
      in_data  = x;
      model_step(x);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic load_cfg(string req, int ord, int rat, int pre, int osh);
      int  e_ord, e_rat, lim;
      bit  e_err;
      idle(4);
      cfg_order     = 3'(ord);
      cfg_ratio     = 17'(rat);
      cfg_pre_shift = 6'(pre);
      cfg_out_shift = 6'(osh);
      cfg_load      = 1'b1;
      in_valid      = 1'b1;          // R8: must be ignored
      in_data       = 16'h7abc;
      @(negedge clk);
      cfg_load = 1'b0;
      in_valid = 1'b0;
      e_err = 1'b0;
      e_ord = ord;
      if (ord == 0) begin e_ord = 1; e_err = 1'b1; end
      else if (ord > 5) begin e_ord = 5; e_err = 1'b1; end
      case (e_ord)
         3:       lim = 32768;
         4:       lim = 2048;
         5:       lim = 512;
         default: lim = 65536;
      endcase
      e_rat = rat;
      if (rat < 4) begin e_rat = 4; e_err = 1'b1; end
      else if (rat > lim) begin e_rat = lim; e_err = 1'b1; end
      check(req, longint'(cfg_err), longint'(e_err));
      m_ord = e_ord;
      m_rat = e_rat;
      m_pre = pre;
      m_osh = osh;
      model_reset();
   endtask

   // Monitor: value and due cycle of every output word
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1 && !done) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected strobe", 1, 0);
         end else begin
            logic [15:0] e;
            int          d;
            string       tg;
            e  = exp_q.pop_front();
            d  = due_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, longint'($signed(out_data)), longint'($signed(e)));
            check("R4 latency", longint'(cyc), longint'(d));
         end
      end
   end

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         done = 1'b1;
         report();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cfg_load = 1'b0; cfg_order = '0; cfg_ratio = '0;
      cfg_pre_shift = '0; cfg_out_shift = '0;
      in_valid = 1'b0; in_data = '0;
      m_ord = 1; m_rat = 4; m_pre = 0; m_osh = 0;
      model_reset();
      repeat (3) @(negedge clk);
      check("R11 out_valid", longint'(out_valid), 0);
      check("R11 out_data",  longint'(out_data), 0);
      check("R11 cfg_err",   longint'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: default order 1, ratio 4, no shifts
      cur_tag = "R11";
      for (int i = 0; i < 8; i++) push(16'(i * 5 - 9));

      // R5 / R3: legal config, ramp input
      load_cfg("R3 clear", 1, 4, 0, 0);
      cur_tag = "R5";
      for (int i = 0; i < 16; i++) push(16'(i * 100 - 700));

      // R9: gaps in in_valid
      load_cfg("R3 clear", 2, 8, 0, 0);
      cur_tag = "R9";
      for (int i = 0; i < 32; i++) begin
         push(16'(i * 3 - 40));
         if (i % 3 == 0) idle(2);
      end

      // R6 / R7: scaling and truncation with random data
      load_cfg("R3 clear", 3, 16, 2, 10);
      cur_tag = "R6";
      for (int i = 0; i < 64; i++) push(16'($urandom_range(0, 4000)) - 16'd2000);

      // R5: fifth order at its largest ratio, DC steps
      load_cfg("R3 clear", 5, 512, 0, 45);
      cur_tag = "R5";
      for (int i = 0; i < 2048; i++) push((i < 1024) ? 16'd1000 : -16'sd700);

      // R3: ratio above the order 4 limit
      load_cfg("R3 clamp", 4, 4000, 0, 40);
      cur_tag = "R3";
      for (int i = 0; i < 3 * 2048; i++) push(16'd300);

      // R1: order 0 and order 7
      load_cfg("R1 low", 0, 6, 0, 0);
      cur_tag = "R1";
      for (int i = 0; i < 12; i++) push(16'(i * 7 + 1));
      load_cfg("R1 high", 7, 20, 0, 0);
      cur_tag = "R7";
      for (int i = 0; i < 40; i++) push(16'($urandom_range(0, 60)) - 16'd30);

      // R2: ratio below minimum
      load_cfg("R2 clamp", 3, 2, 0, 0);
      cur_tag = "R2";
      for (int i = 0; i < 16; i++) push(16'(i - 8));

      // R10: wrap-around with full-range data and a large input shift
      load_cfg("R3 clear", 2, 4, 44, 45);
      cur_tag = "R10";
      for (int i = 0; i < 32; i++) push(16'($urandom()));

      // R8: mid-frame reload discards partial state
      load_cfg("R3 clear", 2, 8, 0, 0);
      for (int i = 0; i < 5; i++) push(16'd3000);
      load_cfg("R8 reload", 2, 8, 0, 0);
      cur_tag = "R8";
      for (int i = 0; i < 16; i++) push(16'(i * 11));

      // R3: order 1 above the 65536 cap
      load_cfg("R3 cap", 1, 100000, 0, 16);
      cur_tag = "R3";
      for (int i = 0; i < 65536; i++) push(16'd5);

      idle(6);
      check("R4 missing outputs", longint'(exp_q.size()), 0);
      done = 1'b1;
      report();
      $finish;
   end

endmodule